// File: doc/BRIEF.md
# Residue Multiply-Accumulate Unit

This block is a multiply-accumulate datapath that keeps every operand as four residue digits, one for each of the pairwise-coprime moduli 2, 3, 5 and 7, so that it represents integers modulo 210. Each digit is carried on its own lane and never exchanges carries with the others. Inside a lane a digit travels as a one-hot set of lines. A multiply or add by a known operand is a routing of those lines to new positions. The routing comes from a small table indexed by that operand.

Each accepted operation multiplies a feature digit set by a weight digit set. It then adds either a bias or the running partial sum, and stores the result in an accumulator. The work is split over five register stages: encode and select the multiply routing, apply it, select the add routing and the addend, apply it, write the accumulator. A new operation may enter on every cycle. When the partial sum it needs is still in flight, that sum is taken from the later stages. Negative numbers use the complement form, digit by digit. For example, -20 is the same residue set as 190.

Top module: `rmac_unit`

## Requirements
- R1: Every residue bus packs four 3-bit binary digits: bits [2:0] hold the value mod 2, bits [5:3] mod 3, bits [8:6] mod 5 and bits [11:9] mod 7. Each accumulator digit is always below its modulus. For example, 25 reads as 12'b100_000_001_001.
- R2: An operation taken with `use_bias` high produces (feature x weight + bias) mod 210 in every digit. For example, 20 x 5 + 0 reads as 12'b010_000_001_000.
- R3: An operation taken with `use_bias` low produces (feature x weight + P) mod 210. P is the result of the most recent earlier accepted operation, or the accumulator contents if no such operation exists.
- R4: Operations may be accepted on consecutive cycles or with any gap. A chain of accumulate operations gives the same results as applying them one at a time in order.
- R5: An operation sampled at rising edge k updates `acc_o` and raises `acc_vld_o` at edge k+4. `acc_vld_o` is then high for exactly one cycle per operation.
- R6: Cycles with `in_valid` low have no effect. `acc_vld_o` stays low and `acc_o` holds its value, whatever the data and select inputs carry.
- R7: At an edge where `clr` is high, the accumulator becomes residue zero (12'b0) and `acc_vld_o` goes low. All operations in flight, and one offered at that edge, are discarded. Accumulation afterwards starts from zero.
- R8: Operands in complement form give results in complement form. For example, feature 0 with bias -20 reads as 12'b001_000_001_000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear: zeroes the accumulator and flushes the pipeline |
| in_valid | input | 1 | An operation is offered this cycle |
| use_bias | input | 1 | 1: add the bias; 0: add the running partial sum |
| feat_i | input | 12 | Feature operand, residue digits packed as in R1 |
| wgt_i | input | 12 | Weight operand, residue digits packed as in R1 |
| bias_i | input | 12 | Bias operand, residue digits packed as in R1 |
| acc_o | output | 12 | Accumulator contents, residue digits packed as in R1 |
| acc_vld_o | output | 1 | High for one cycle after each accumulator write |

## Verification
The assertions assume that every operand digit is below its modulus. An out-of-range digit would drive a line that no routing entry reads. They also assume that `clr` is high at the first clock edge, so the five-cycle history they look back over starts from a flushed pipeline. The bench builds every operand from an integer in 0 to 209 and converts it to residues, which keeps each digit in range. It holds `clr` high for the first cycles and scrambles the data inputs only while `in_valid` is low.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

   // number of residue digits carried per operand
   localparam int unsigned NDIG = 4;

   // which modular operation a routing table implements
   typedef enum logic {
      ROUTE_MUL,
      ROUTE_ADD
   } route_kind_e;

   // where the stage-3 partial sum is taken from
   typedef enum logic [1:0] {
      SRC_ACC = 2'd0,   // accumulator register
      SRC_WB  = 2'd1,   // value being written this cycle
      SRC_ADD = 2'd2    // stage-4 adder output
   } psum_src_e;

   function automatic int unsigned gcd_u(int unsigned a, int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

endpackage

// File: rtl/rmac_route_lut.sv
module rmac_route_lut
   import rmac_pkg::*;
#(
   parameter int unsigned MOD   = 7,
   parameter int unsigned DIG_W = 3,
   parameter route_kind_e KIND  = ROUTE_MUL
) (
   input  logic [DIG_W-1:0]                   operand_i,
   output logic [(1<<DIG_W)-1:0][DIG_W-1:0]   route_o
);
   localparam int unsigned LANE_W = 1 << DIG_W;

   // route_o[i] is the destination line of source line i
   if (KIND == ROUTE_MUL) begin : g_mul
      always_comb begin
         for (int unsigned i = 0; i < LANE_W; i++) begin
            if (i < MOD)
               route_o[i] = DIG_W'((i * 32'(operand_i)) % MOD);
            else
               route_o[i] = '0;
         end
      end
   end else begin : g_add
      always_comb begin
         for (int unsigned i = 0; i < LANE_W; i++) begin
            if (i < MOD)
               route_o[i] = DIG_W'((i + 32'(operand_i)) % MOD);
            else
               route_o[i] = '0;
         end
      end
   end

endmodule

// File: rtl/rmac_route_apply.sv
module rmac_route_apply #(
   parameter int unsigned MOD   = 7,
   parameter int unsigned DIG_W = 3
) (
   input  logic [(1<<DIG_W)-1:0]              lines_i,
   input  logic [(1<<DIG_W)-1:0][DIG_W-1:0]   route_i,
   output logic [(1<<DIG_W)-1:0]              lines_o
);
   localparam int unsigned LANE_W = 1 << DIG_W;

   // each live source line lights its destination; lines above MOD are dead
   always_comb begin
      lines_o = '0;
      for (int unsigned i = 0; i < LANE_W; i++) begin
         if (i < MOD)
            lines_o[route_i[i]] = lines_o[route_i[i]] | lines_i[i];
      end
   end

endmodule

// File: rtl/rmac_lane.sv
module rmac_lane
   import rmac_pkg::*;
#(
   parameter int unsigned MOD   = 7,
   parameter int unsigned DIG_W = 3
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             wr_en,
   input  logic             take_bias,
   input  psum_src_e        psum_src,
   input  logic [DIG_W-1:0] feat_d,
   input  logic [DIG_W-1:0] wgt_d,
   input  logic [DIG_W-1:0] bias_d,
   output logic [DIG_W-1:0] acc_d
);
   localparam int unsigned LANE_W = 1 << DIG_W;

   typedef logic [LANE_W-1:0]            lines_t;
   typedef logic [LANE_W-1:0][DIG_W-1:0] route_t;

   localparam lines_t ZERO_LINES = lines_t'(1);

   function automatic lines_t to_lines(logic [DIG_W-1:0] d);
      lines_t l;
      l    = '0;
      l[d] = 1'b1;
      return l;
   endfunction

   function automatic logic [DIG_W-1:0] to_digit(lines_t l);
      logic [DIG_W-1:0] d;
      d = '0;
      for (int unsigned i = 0; i < LANE_W; i++)
         if (l[i]) d = d | DIG_W'(i);
      return d;
   endfunction

   // stage 1: encode feature, pick multiply routing from the weight
   lines_t           feat_lines;
   route_t           mul_route;
   lines_t           s1_feat;
   route_t           s1_route;
   logic [DIG_W-1:0] s1_bias;

   assign feat_lines = to_lines(feat_d);

   rmac_route_lut #(.MOD(MOD), .DIG_W(DIG_W), .KIND(ROUTE_MUL)) u_mul_lut (
      .operand_i (wgt_d),
      .route_o   (mul_route)
   );

   always_ff @(posedge clk) begin
      s1_feat  <= feat_lines;
      s1_route <= mul_route;
      s1_bias  <= bias_d;
   end

   // stage 2: apply multiply routing
   lines_t           prod_lines;
   lines_t           s2_prod;
   logic [DIG_W-1:0] s2_bias;

   rmac_route_apply #(.MOD(MOD), .DIG_W(DIG_W)) u_mul (
      .lines_i (s1_feat),
      .route_i (s1_route),
      .lines_o (prod_lines)
   );

   always_ff @(posedge clk) begin
      s2_prod <= prod_lines;
      s2_bias <= s1_bias;
   end

   // stage 3: pick add routing from the product, select the addend
   route_t add_route;
   lines_t addend;
   lines_t s3_route_dummy_unused;
   route_t s3_route;
   lines_t s3_addend;
   lines_t sum_lines;
   lines_t s4_sum;
   lines_t acc_lines;

   assign s3_route_dummy_unused = '0;

   rmac_route_lut #(.MOD(MOD), .DIG_W(DIG_W), .KIND(ROUTE_ADD)) u_add_lut (
      .operand_i (to_digit(s2_prod)),
      .route_o   (add_route)
   );

   always_comb begin
      if (take_bias) begin
         addend = to_lines(s2_bias);
      end else begin
         case (psum_src)
            SRC_ADD: addend = sum_lines;
            SRC_WB:  addend = s4_sum;
            default: addend = acc_lines;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      s3_route  <= add_route;
      s3_addend <= addend;
   end

   // stage 4: apply add routing
   rmac_route_apply #(.MOD(MOD), .DIG_W(DIG_W)) u_add (
      .lines_i (s3_addend),
      .route_i (s3_route),
      .lines_o (sum_lines)
   );

   always_ff @(posedge clk) begin
      s4_sum <= sum_lines;
   end

   // stage 5: accumulator write, clear wins
   always_ff @(posedge clk) begin
      if (clr)
         acc_lines <= ZERO_LINES;
      else if (wr_en)
         acc_lines <= s4_sum;
   end

   assign acc_d = to_digit(acc_lines);

endmodule

// File: rtl/rmac_unit.sv
module rmac_unit
   import rmac_pkg::*;
#(
   parameter int unsigned MOD0  = 2,
   parameter int unsigned MOD1  = 3,
   parameter int unsigned MOD2  = 5,
   parameter int unsigned MOD3  = 7,
   parameter int unsigned DIG_W = 3
) (
   input  logic                  clk,
   input  logic                  clr,
   input  logic                  in_valid,
   input  logic                  use_bias,
   input  logic [NDIG*DIG_W-1:0] feat_i,
   input  logic [NDIG*DIG_W-1:0] wgt_i,
   input  logic [NDIG*DIG_W-1:0] bias_i,
   output logic [NDIG*DIG_W-1:0] acc_o,
   output logic                  acc_vld_o
);
   localparam int unsigned MODS [NDIG] = '{MOD0, MOD1, MOD2, MOD3};
   localparam int unsigned LANE_W      = 1 << DIG_W;

   // elaboration-time parameter checks
   for (genvar i = 0; i < NDIG; i++) begin : g_mod_chk
      if (MODS[i] < 2 || MODS[i] > LANE_W) begin : g_bad_range
         $error("rmac_unit: modulus %0d does not fit a %0d-bit digit", MODS[i], DIG_W);
      end
      for (genvar j = i + 1; j < NDIG; j++) begin : g_pair
         if (gcd_u(MODS[i], MODS[j]) != 1) begin : g_bad_pair
            $error("rmac_unit: moduli %0d and %0d share a factor", MODS[i], MODS[j]);
         end
      end
   end

   // control pipeline: valid bits for stages 1..4, select for stages 1..2
   logic [4:1] vld;
   logic [2:1] bsel;
   psum_src_e  psum_src;

   always_ff @(posedge clk) begin
      if (clr)
         vld <= '0;
      else
         vld <= {vld[3:1], in_valid};
      bsel      <= {bsel[1], use_bias};
      acc_vld_o <= vld[4] & ~clr;
   end

   // nearest older operation still in flight supplies the partial sum
   always_comb begin
      if (vld[3])
         psum_src = SRC_ADD;
      else if (vld[4])
         psum_src = SRC_WB;
      else
         psum_src = SRC_ACC;
   end

   for (genvar g = 0; g < NDIG; g++) begin : g_lane
      rmac_lane #(.MOD(MODS[g]), .DIG_W(DIG_W)) u_lane (
         .clk       (clk),
         .clr       (clr),
         .wr_en     (vld[4]),
         .take_bias (bsel[2]),
         .psum_src  (psum_src),
         .feat_d    (feat_i[g*DIG_W +: DIG_W]),
         .wgt_d     (wgt_i[g*DIG_W +: DIG_W]),
         .bias_d    (bias_i[g*DIG_W +: DIG_W]),
         .acc_d     (acc_o[g*DIG_W +: DIG_W])
      );
   end

endmodule

// File: rtl/rmac_unit_chk.sv
module rmac_unit_chk
   import rmac_pkg::*;
#(
   parameter int unsigned MOD0  = 2,
   parameter int unsigned MOD1  = 3,
   parameter int unsigned MOD2  = 5,
   parameter int unsigned MOD3  = 7,
   parameter int unsigned DIG_W = 3
) (
   input logic                  clk,
   input logic                  clr,
   input logic                  in_valid,
   input logic                  use_bias,
   input logic [NDIG*DIG_W-1:0] feat_i,
   input logic [NDIG*DIG_W-1:0] wgt_i,
   input logic [NDIG*DIG_W-1:0] bias_i,
   input logic [NDIG*DIG_W-1:0] acc_o,
   input logic                  acc_vld_o
);
   localparam int unsigned MODS [NDIG] = '{MOD0, MOD1, MOD2, MOD3};

   // R7
   clr_flush_chk: assert property (@(posedge clk)
      clr |=> (acc_o == '0 && !acc_vld_o));

   // R5
   vld_source_chk: assert property (@(posedge clk) disable iff (clr)
      acc_vld_o |-> $past(in_valid, 5));

   // R5
   issue_latency_chk: assert property (@(posedge clk) disable iff (clr)
      ($past(in_valid, 5) && !$past(clr, 5) && !$past(clr, 4) && !$past(clr, 3)
       && !$past(clr, 2) && !$past(clr, 1)) |-> acc_vld_o);

   // R6
   acc_hold_chk: assert property (@(posedge clk) disable iff (clr)
      (!acc_vld_o && !$past(clr)) |-> $stable(acc_o));

   for (genvar d = 0; d < NDIG; d++) begin : g_dig
      localparam int unsigned M = MODS[d];

      // R1
      digit_range_chk: assert property (@(posedge clk) disable iff (clr)
         32'(acc_o[d*DIG_W +: DIG_W]) < M);

      // R2
      bias_result_chk: assert property (@(posedge clk) disable iff (clr)
         (acc_vld_o && $past(use_bias, 5)) |->
            (32'(acc_o[d*DIG_W +: DIG_W]) ==
             ((32'($past(feat_i[d*DIG_W +: DIG_W], 5)) *
               32'($past(wgt_i[d*DIG_W +: DIG_W], 5)) +
               32'($past(bias_i[d*DIG_W +: DIG_W], 5))) % M)));
   end

endmodule

bind rmac_unit rmac_unit_chk #(
   .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2), .MOD3(MOD3), .DIG_W(DIG_W)
) u_chk (
   .clk       (clk),
   .clr       (clr),
   .in_valid  (in_valid),
   .use_bias  (use_bias),
   .feat_i    (feat_i),
   .wgt_i     (wgt_i),
   .bias_i    (bias_i),
   .acc_o     (acc_o),
   .acc_vld_o (acc_vld_o)
);

// File: tb/rmac_unit_test.sv
module rmac_unit_test;

   localparam int RANGE = 210;

   logic        clk = 1'b0;
   logic        clr;
   logic        in_valid;
   logic        use_bias;
   logic [11:0] feat_i;
   logic [11:0] wgt_i;
   logic [11:0] bias_i;
   logic [11:0] acc_o;
   logic        acc_vld_o;

   always #5 clk = ~clk;

   rmac_unit uut (
      .clk       (clk),
      .clr       (clr),
      .in_valid  (in_valid),
      .use_bias  (use_bias),
      .feat_i    (feat_i),
      .wgt_i     (wgt_i),
      .bias_i    (bias_i),
      .acc_o     (acc_o),
      .acc_vld_o (acc_vld_o)
   );

   int    n_checks = 0;
   int    n_fails  = 0;
   int    cyc      = 0;
   int    model_acc = 0;
   bit    done     = 1'b0;
   int    exp_q[$];
   int    stamp_q[$];
   string tag_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   // binary value -> packed residues, layout of R1
   function automatic logic [11:0] to_res(int x);
      int v;
      v = ((x % RANGE) + RANGE) % RANGE;
      return {3'(v % 7), 3'(v % 5), 3'(v % 3), 3'(v % 2)};
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic scramble();
      feat_i   = to_res(int'($urandom_range(0, RANGE - 1)));
      wgt_i    = to_res(int'($urandom_range(0, RANGE - 1)));
      bias_i   = to_res(int'($urandom_range(0, RANGE - 1)));
      use_bias = 1'($urandom_range(0, 1));
   endtask

   // driver: called at a falling edge, offers one operation for one cycle
   task automatic issue(int f, int w, int b, bit sel, string tag);
      int r;
      r = sel ? (f * w + b) % RANGE : (f * w + model_acc) % RANGE;
      model_acc = r;
      exp_q.push_back(r);
      stamp_q.push_back(cyc);
      tag_q.push_back(tag);
      in_valid = 1'b1;
      use_bias = sel;
      feat_i   = to_res(f);
      wgt_i    = to_res(w);
      bias_i   = to_res(b);
      @(negedge clk);
      in_valid = 1'b0;
      scramble();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         scramble();
         @(negedge clk);
      end
   endtask

   task automatic finish_test();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (acc_vld_o === 1'b1) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", "result with no operation outstanding", int'(acc_o), 0);
         end else begin
            int    e;
            int    s;
            string t;
            e = exp_q.pop_front();
            s = stamp_q.pop_front();
            t = tag_q.pop_front();
            check(acc_o === to_res(e), t, "accumulator value", int'(acc_o), int'(to_res(e)));
            check(cyc - s == 5, "R5", "result latency in cycles", cyc - s, 5);
         end
      end
   end

   initial begin
      clr      = 1'b1;
      in_valid = 1'b0;
      use_bias = 1'b0;
      feat_i   = '0;
      wgt_i    = '0;
      bias_i   = '0;
      repeat (3) @(negedge clk);

      // reset state
      check(acc_o === 12'b0, "R7", "accumulator after clear", int'(acc_o), 0);
      check(acc_vld_o === 1'b0, "R7", "valid after clear", int'(acc_vld_o), 0);
      clr = 1'b0;
      idle(2);

      // worked examples of the digit layout and bias mode
      issue(20, 1, 5, 1'b1, "R1");
      idle(6);
      check(acc_o === 12'b100_000_001_001, "R1", "20*1+5 layout", int'(acc_o), 12'b100_000_001_001);
      issue(20, 5, 0, 1'b1, "R2");
      idle(6);
      check(acc_o === 12'b010_000_001_000, "R2", "20*5+0", int'(acc_o), 12'b010_000_001_000);

      // complement-form operands
      issue(0, 9, RANGE - 20, 1'b1, "R8");
      idle(6);
      check(acc_o === 12'b001_000_001_000, "R8", "0+(-20)", int'(acc_o), 12'b001_000_001_000);
      issue(3, RANGE - 7, 0, 1'b0, "R8");
      issue(RANGE - 4, RANGE - 5, 1, 1'b0, "R8");
      idle(6);

      // several bias-mode patterns with gaps
      issue(209, 209, 209, 1'b1, "R2");
      idle(1);
      issue(13, 17, 100, 1'b1, "R2");
      idle(3);
      issue(0, 0, 0, 1'b1, "R2");
      idle(6);

      // accumulate chains, back to back
      issue(7, 11, 3, 1'b1, "R3");
      for (int i = 0; i < 8; i++)
         issue(i + 2, 3 * i + 1, 0, 1'b0, "R4");
      idle(6);

      // accumulate with gaps of one, two and three cycles
      issue(5, 5, 50, 1'b1, "R3");
      for (int g = 1; g <= 3; g++) begin
         issue(g + 10, 19, 0, 1'b0, "R4");
         idle(g);
         issue(g + 30, 23, 0, 1'b0, "R4");
         idle(g);
      end
      idle(6);

      // accumulate from the stored accumulator after a long pause
      issue(6, 6, 0, 1'b0, "R3");
      idle(6);

      // hold: no operation, inputs moving
      begin
         logic [11:0] held;
         held = acc_o;
         idle(12);
         check(acc_o === held, "R6", "accumulator held while idle", int'(acc_o), int'(held));
      end

      // clear with operations in flight and one offered at the clear edge
      issue(40, 2, 1, 1'b1, "R7");
      issue(41, 3, 0, 1'b0, "R7");
      issue(42, 4, 0, 1'b0, "R7");
      clr      = 1'b1;
      in_valid = 1'b1;
      use_bias = 1'b1;
      feat_i   = to_res(99);
      wgt_i    = to_res(99);
      bias_i   = to_res(99);
      exp_q.delete();
      stamp_q.delete();
      tag_q.delete();
      model_acc = 0;
      @(negedge clk);
      clr      = 1'b0;
      in_valid = 1'b0;
      check(acc_o === 12'b0, "R7", "accumulator zero after mid-flight clear", int'(acc_o), 0);
      check(acc_vld_o === 1'b0, "R7", "valid low after clear", int'(acc_vld_o), 0);
      idle(8);
      check(acc_o === 12'b0, "R7", "flushed operations never written", int'(acc_o), 0);
      issue(8, 9, 0, 1'b0, "R7");
      idle(6);

      // mixed stream
      for (int n = 0; n < 300; n++) begin
         issue(int'($urandom_range(0, RANGE - 1)), int'($urandom_range(0, RANGE - 1)),
               int'($urandom_range(0, RANGE - 1)), ($urandom_range(0, 3) == 0), "R4");
         idle(int'($urandom_range(0, 3)));
      end
      idle(8);

      check(exp_q.size() == 0, "R5", "operations left without a result", exp_q.size(), 0);
      done = 1'b1;
      finish_test();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R5 watchdog: actual timeout expected completion");
         finish_test();
      end
   end

endmodule